// File: doc/BRIEF.md
# Internal Data Memory Address Decoder with Bit Access

This block sits between the execution unit of an 8-bit controller and its internal data storage. Each access brings an 8-bit address and an addressing mode, and the block picks the target. The target is the lower 128 bytes of on-chip RAM, the optional upper 128 bytes, or the special function register (SFR) space. The block holds the RAM itself. SFRs sit outside it and are reached through a plain register port, because what each peripheral register contains, and any side effect of touching it, belong to the peripherals.

The upper half of the byte address range has two meanings. Direct addressing there selects SFRs, while indirect addressing selects the upper RAM. Bit addressing has two windows. The low one covers a 16-byte bit-addressable RAM area above the register banks, and the high one covers the SFRs whose address has its three low bits clear. A bit write reads the target byte, replaces one bit and writes the byte back, all within the cycle of the access. A register mode turns a register number 0..7 into a RAM byte, using the two bank-select bits that come from the status register.

Top module: `mem_bitdec`

## Requirements
- R1: Mode encoding is 00 direct, 01 indirect, 10 bit, 11 register. Under direct (00) or indirect (01) mode, an address below 80H reaches the same lower RAM byte. A write in one mode is read back by the other.
- R2: With UPPER_RAM=1, indirect (01) mode at 80H..FFH reads and writes the upper RAM. It never raises sfr_re or sfr_we.
- R3: Direct (00) mode at 80H..FFH goes to the SFR port. sfr_addr equals the address, acc_rdata equals sfr_rdata, and a write drives sfr_we with sfr_wdata equal to acc_wdata. Upper RAM is left unchanged.
- R4: Bit (10) mode with a bit address below 80H selects RAM byte 20H + address[6:3] and bit address[2:0]. The bit read appears in acc_rdata[0], and acc_rdata[7:1] is 0.
- R5: Bit (10) mode with a bit address of 80H or above selects the SFR at address with bits [2:0] cleared, and bit address[2:0] within it. The bit is read from sfr_rdata and written back through sfr_wdata.
- R6: A bit write, with the value in acc_wdata[0], changes only the selected bit of the target byte. The new value is visible to the next access.
- R7: Register (11) mode maps register n = address[2:0] to RAM byte bank_sel × 8 + n.
- R8: With UPPER_RAM=0, indirect (01) mode at 80H..FFH reads 00H, and writes there change no storage.
- R9: While acc_en is low, no RAM byte changes and sfr_we stays low.
- R10: Reset clears every RAM byte to 00H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_mode | input | 2 | 00 direct, 01 indirect, 10 bit, 11 register |
| acc_addr | input | 8 | Byte address, bit address or register number |
| acc_we | input | 1 | Write (byte, or bit read-modify-write) |
| acc_wdata | input | 8 | Write byte; bit value in bit 0 for bit mode |
| acc_rdata | output | 8 | Read byte, or selected bit in bit 0 |
| bank_sel | input | 2 | Register bank select from the status register |
| sfr_addr | output | 8 | SFR byte address |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_wdata | output | 8 | SFR write byte (merged byte for bit writes) |
| sfr_rdata | input | 8 | SFR read byte returned by the peripherals |

## Verification
The bench builds two copies on the same inputs, one with UPPER_RAM=1 and one with UPPER_RAM=0. With both sizes present, one sweep of indirect accesses at 80H..FFH exercises both the upper RAM and the read-as-zero, write-ignored behaviour. The 8-bit address space is small, so every byte address in every mode, all 256 bit addresses and all four banks are swept. Expected bytes and merged bits are derived arithmetically from the address and kept in shadow arrays in the bench.

// File: rtl/mem_bitdec_pkg.sv
package mem_bitdec_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int BIDX_W = 3;

  typedef enum logic [1:0] {
    MODE_DIR = 2'b00,
    MODE_IND = 2'b01,
    MODE_BIT = 2'b10,
    MODE_REG = 2'b11
  } acc_mode_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'b00,
    TGT_RAM  = 2'b01,
    TGT_SFR  = 2'b10
  } tgt_e;

  typedef struct packed {
    tgt_e              tgt;
    logic [ADDR_W-1:0] byte_addr;
    logic [BIDX_W-1:0] bit_idx;
    logic              is_bit;
  } dec_t;
endpackage

// File: rtl/mem_bitdec_decode.sv
module mem_bitdec_decode
  import mem_bitdec_pkg::*;
#(
  parameter bit               UPPER_RAM = 1'b1,
  parameter logic [ADDR_W-1:0] BIT_BASE = 8'h20
) (
  input  logic [1:0]        mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        bank,
  output dec_t              dec
);
  localparam int LOW_IDX_W = ADDR_W - 1 - BIDX_W;

  logic hi_half;
  assign hi_half = addr[ADDR_W-1];

  always_comb begin
    dec = '0;
    unique case (acc_mode_e'(mode))
      MODE_DIR: begin
        dec.tgt       = hi_half ? TGT_SFR : TGT_RAM;
        dec.byte_addr = addr;
      end
      MODE_IND: begin
        if (!hi_half)       dec.tgt = TGT_RAM;
        else if (UPPER_RAM) dec.tgt = TGT_RAM;
        else                dec.tgt = TGT_NONE;
        dec.byte_addr = addr;
      end
      MODE_BIT: begin
        dec.is_bit  = 1'b1;
        dec.bit_idx = addr[BIDX_W-1:0];
        if (hi_half) begin
          dec.tgt       = TGT_SFR;
          dec.byte_addr = {addr[ADDR_W-1:BIDX_W], {BIDX_W{1'b0}}};
        end else begin
          dec.tgt       = TGT_RAM;
          dec.byte_addr = BIT_BASE +
            {{(ADDR_W-LOW_IDX_W){1'b0}}, addr[ADDR_W-2:BIDX_W]};
        end
      end
      MODE_REG: begin
        dec.tgt       = TGT_RAM;
        dec.byte_addr = {{(ADDR_W-2-BIDX_W){1'b0}}, bank, addr[BIDX_W-1:0]};
      end
      default: dec = '0;
    endcase
  end
endmodule

// File: rtl/mem_bitdec_bitops.sv
module mem_bitdec_bitops
  import mem_bitdec_pkg::*;
(
  input  logic [DATA_W-1:0] byte_in,
  input  logic [BIDX_W-1:0] idx,
  input  logic              bit_val,
  output logic              bit_out,
  output logic [DATA_W-1:0] byte_merged
);
  assign bit_out = byte_in[idx];

  for (genvar g = 0; g < DATA_W; g++) begin : g_merge
    assign byte_merged[g] = (idx == BIDX_W'(g)) ? bit_val : byte_in[g];
  end
endmodule

// File: rtl/mem_bitdec_ram.sv
module mem_bitdec_ram
  import mem_bitdec_pkg::*;
#(
  parameter int DEPTH = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DEPTH-1:0][DATA_W-1:0] mem_q, mem_d;
  logic [IDX_W-1:0] widx, ridx;

  assign widx  = waddr[IDX_W-1:0];
  assign ridx  = raddr[IDX_W-1:0];
  assign rdata = mem_q[ridx];

  always_comb begin
    mem_d = mem_q;
    if (wr_en) mem_d[widx] = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (wr_en) mem_q <= mem_d;
  end
endmodule

// File: rtl/mem_bitdec.sv
module mem_bitdec
  import mem_bitdec_pkg::*;
#(
  parameter bit               UPPER_RAM = 1'b1,
  parameter logic [7:0]       BIT_BASE  = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_en,
  input  logic [1:0] acc_mode,
  input  logic [7:0] acc_addr,
  input  logic       acc_we,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  input  logic [1:0] bank_sel,
  output logic [7:0] sfr_addr,
  output logic       sfr_re,
  output logic       sfr_we,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  localparam int RAM_DEPTH = UPPER_RAM ? 256 : 128;

  logic [1:0] rst_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= '0;
    else        rst_q <= {rst_q[0], 1'b1};
  end
  assign rst_sync_n = rst_q[1];

  dec_t              dec;
  logic [DATA_W-1:0] ram_rd, byte_src, byte_merged, byte_wr;
  logic              bit_rd, wr_req, ram_we;

  mem_bitdec_decode #(.UPPER_RAM(UPPER_RAM), .BIT_BASE(BIT_BASE)) u_decode (
    .mode (acc_mode),
    .addr (acc_addr),
    .bank (bank_sel),
    .dec  (dec)
  );

  mem_bitdec_ram #(.DEPTH(RAM_DEPTH)) u_ram (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (ram_we),
    .waddr (dec.byte_addr),
    .wdata (byte_wr),
    .raddr (dec.byte_addr),
    .rdata (ram_rd)
  );

  mem_bitdec_bitops u_bitops (
    .byte_in     (byte_src),
    .idx         (dec.bit_idx),
    .bit_val     (acc_wdata[0]),
    .bit_out     (bit_rd),
    .byte_merged (byte_merged)
  );

  always_comb begin
    unique case (dec.tgt)
      TGT_RAM: byte_src = ram_rd;
      TGT_SFR: byte_src = sfr_rdata;
      default: byte_src = '0;
    endcase
  end

  assign byte_wr   = dec.is_bit ? byte_merged : acc_wdata;
  assign acc_rdata = dec.is_bit ? {{(DATA_W-1){1'b0}}, bit_rd} : byte_src;

  assign wr_req    = acc_en && acc_we && rst_sync_n;
  assign ram_we    = wr_req && (dec.tgt == TGT_RAM);
  assign sfr_we    = wr_req && (dec.tgt == TGT_SFR);
  assign sfr_re    = acc_en && (dec.tgt == TGT_SFR);
  assign sfr_addr  = dec.byte_addr;
  assign sfr_wdata = byte_wr;
endmodule

// File: rtl/mem_bitdec_chk.sv
module mem_bitdec_chk #(
  parameter bit UPPER_RAM = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       acc_en,
  input logic [1:0] acc_mode,
  input logic [7:0] acc_addr,
  input logic       acc_we,
  input logic [7:0] acc_wdata,
  input logic [7:0] acc_rdata,
  input logic [7:0] sfr_addr,
  input logic       sfr_re,
  input logic       sfr_we,
  input logic [7:0] sfr_wdata,
  input logic [7:0] sfr_rdata
);
  p_sfr_we_gated_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_we |-> (acc_en && acc_we));

  p_indirect_no_sfr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b01) |-> (!sfr_re && !sfr_we));

  p_direct_sfr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b00 && acc_addr[7])
      |-> (sfr_re && sfr_addr == acc_addr && acc_rdata == sfr_rdata));

  p_bit_read_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b10) |-> (acc_rdata[7:1] == 7'd0));

  p_bit_sfr_addr_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_mode == 2'b10 && acc_addr[7])
      |-> (sfr_addr == {acc_addr[7:3], 3'b000}
           && acc_rdata[0] == sfr_rdata[acc_addr[2:0]]));

  p_bit_merge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sfr_we && acc_mode == 2'b10)
      |-> ($countones(sfr_wdata ^ sfr_rdata) <= 1
           && sfr_wdata[acc_addr[2:0]] == acc_wdata[0]));

  if (!UPPER_RAM) begin : g_small
    p_small_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_en && acc_mode == 2'b01 && acc_addr[7]) |-> (acc_rdata == 8'h00));
  end
endmodule

bind mem_bitdec mem_bitdec_chk #(.UPPER_RAM(UPPER_RAM)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .acc_en    (acc_en),
  .acc_mode  (acc_mode),
  .acc_addr  (acc_addr),
  .acc_we    (acc_we),
  .acc_wdata (acc_wdata),
  .acc_rdata (acc_rdata),
  .sfr_addr  (sfr_addr),
  .sfr_re    (sfr_re),
  .sfr_we    (sfr_we),
  .sfr_wdata (sfr_wdata),
  .sfr_rdata (sfr_rdata)
);

// File: tb/mem_bitdec_tb.sv
module mem_bitdec_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk, rst_n, acc_en, acc_we;
  logic [1:0] acc_mode, bank_sel;
  logic [7:0] acc_addr, acc_wdata;
  logic [7:0] rdata_l, rdata_s;
  logic [7:0] sfr_addr_l, sfr_wdata_l, sfr_rdata_l;
  logic       sfr_re_l, sfr_we_l;
  logic [7:0] sfr_addr_s, sfr_wdata_s;
  logic       sfr_re_s, sfr_we_s;

  int checks = 0;
  int errors = 0;
  logic [7:0] periph [128];
  logic [7:0] exp_ram [256];
  logic [7:0] exp_sfr [128];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  mem_bitdec #(.UPPER_RAM(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .acc_rdata(rdata_l), .bank_sel(bank_sel), .sfr_addr(sfr_addr_l),
    .sfr_re(sfr_re_l), .sfr_we(sfr_we_l), .sfr_wdata(sfr_wdata_l),
    .sfr_rdata(sfr_rdata_l)
  );

  mem_bitdec #(.UPPER_RAM(1'b0)) u_dut_small (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_mode(acc_mode),
    .acc_addr(acc_addr), .acc_we(acc_we), .acc_wdata(acc_wdata),
    .acc_rdata(rdata_s), .bank_sel(bank_sel), .sfr_addr(sfr_addr_s),
    .sfr_re(sfr_re_s), .sfr_we(sfr_we_s), .sfr_wdata(sfr_wdata_s),
    .sfr_rdata(8'h00)
  );

  // Peripheral register model on the SFR port of the large instance.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) periph[i] <= 8'((i * 13) + 7);
    end else if (sfr_we_l) begin
      periph[sfr_addr_l[6:0]] <= sfr_wdata_l;
    end
  end
  assign sfr_rdata_l = periph[sfr_addr_l[6:0]];

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%02h exp=%02h", req, act, exp);
    end
  endtask

  task automatic op_write(input logic [1:0] md, input logic [7:0] ad, input logic [7:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_mode = md; acc_addr = ad; acc_we = 1'b1; acc_wdata = d;
    @(posedge clk);
    #1;
    acc_en = 1'b0; acc_we = 1'b0;
  endtask

  task automatic op_read(input logic [1:0] md, input logic [7:0] ad);
    @(negedge clk);
    acc_en = 1'b1; acc_mode = md; acc_addr = ad; acc_we = 1'b0; acc_wdata = 8'h00;
    #1;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog act=%02h exp=%02h", 8'h00, 8'h01);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_we = 1'b0; acc_mode = 2'b00;
    acc_addr = 8'h00; acc_wdata = 8'h00; bank_sel = 2'b00;
    for (int i = 0; i < 256; i++) exp_ram[i] = 8'h00;
    for (int i = 0; i < 128; i++) exp_sfr[i] = 8'((i * 13) + 7);
    repeat (5) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: every RAM byte reads zero after reset
    for (int a = 0; a < 256; a++) begin
      op_read(2'b01, 8'(a));
      check("R10 reset", rdata_l, 8'h00);
    end

    // R1: direct writes below 80H read back indirectly
    for (int a = 0; a < 128; a++) begin
      exp_ram[a] = 8'((a * 7) + 3);
      op_write(2'b00, 8'(a), exp_ram[a]);
    end
    for (int a = 0; a < 128; a++) begin
      op_read(2'b01, 8'(a));
      check("R1 indirect", rdata_l, exp_ram[a]);
    end

    // R2: upper RAM via indirect
    for (int a = 128; a < 256; a++) begin
      exp_ram[a] = ~8'(a);
      op_write(2'b01, 8'(a), exp_ram[a]);
      check("R2 no sfr write", {7'd0, sfr_we_l}, 8'h00);
    end
    for (int a = 128; a < 256; a++) begin
      op_read(2'b01, 8'(a));
      check("R2 upper", rdata_l, exp_ram[a]);
    end

    // R3: direct 80H..FFH reaches the SFR port
    for (int a = 128; a < 256; a++) begin
      op_read(2'b00, 8'(a));
      check("R3 sfr read", rdata_l, exp_sfr[a-128]);
      exp_sfr[a-128] = 8'(a) ^ 8'h3C;
      op_write(2'b00, 8'(a), exp_sfr[a-128]);
    end
    for (int a = 128; a < 256; a++) begin
      op_read(2'b00, 8'(a));
      check("R3 sfr readback", rdata_l, exp_sfr[a-128]);
      op_read(2'b01, 8'(a));
      check("R3 upper untouched", rdata_l, exp_ram[a]);
    end

    // R4, R6: bit window in RAM
    for (int b = 0; b < 128; b++) begin
      logic v;
      int   by;
      v  = 1'(b ^ (b >> 4) ^ (b >> 1));
      by = 32 + (b >> 3);
      exp_ram[by][b & 7] = v;
      op_write(2'b10, 8'(b), {7'd0, v});
      op_read(2'b10, 8'(b));
      check("R4 bit read", rdata_l, {7'd0, v});
      check("R6 bit small", rdata_s, {7'd0, v});
    end
    for (int a = 0; a < 128; a++) begin
      op_read(2'b00, 8'(a));
      check("R6 bytes intact", rdata_l, exp_ram[a]);
    end

    // R5, R6: bit window in SFR space
    for (int b = 128; b < 256; b++) begin
      logic v;
      int   by;
      v  = ~1'(b >> 1);
      by = (b & 8'hF8) - 128;
      exp_sfr[by][b & 7] = v;
      op_write(2'b10, 8'(b), {7'd0, v});
      op_read(2'b10, 8'(b));
      check("R5 sfr bit", rdata_l, {7'd0, v});
    end
    for (int a = 128; a < 256; a++) begin
      op_read(2'b00, 8'(a));
      check("R5 sfr bytes", rdata_l, exp_sfr[a-128]);
    end

    // R7: register banks
    for (int bk = 0; bk < 4; bk++) begin
      bank_sel = 2'(bk);
      for (int n = 0; n < 8; n++) begin
        exp_ram[bk*8+n] = 8'(8'h90 + bk*8 + n);
        op_write(2'b11, 8'(n), exp_ram[bk*8+n]);
        op_read(2'b11, 8'(n));
        check("R7 reg read", rdata_l, exp_ram[bk*8+n]);
      end
    end
    for (int a = 0; a < 32; a++) begin
      op_read(2'b00, 8'(a));
      check("R7 bank byte", rdata_l, exp_ram[a]);
    end
    bank_sel = 2'b00;

    // R8: small configuration ignores indirect upper accesses
    for (int a = 128; a < 256; a++) begin
      op_read(2'b01, 8'(a));
      check("R8 small zero", rdata_s, 8'h00);
    end
    for (int a = 0; a < 128; a++) begin
      op_read(2'b00, 8'(a));
      check("R8 small lower", rdata_s, exp_ram[a]);
    end

    // R9: writes with access disabled change nothing
    @(negedge clk);
    acc_en = 1'b0; acc_we = 1'b1; acc_mode = 2'b00; acc_addr = 8'h10; acc_wdata = 8'hFF;
    #1;
    check("R9 sfr_we low", {7'd0, sfr_we_l}, 8'h00);
    @(negedge clk);
    acc_addr = 8'h90;
    #1;
    check("R9 sfr_we low hi", {7'd0, sfr_we_l}, 8'h00);
    @(posedge clk);
    #1;
    acc_we = 1'b0;
    op_read(2'b00, 8'h10);
    check("R9 ram kept", rdata_l, exp_ram[16]);
    op_read(2'b00, 8'h90);
    check("R9 sfr kept", rdata_l, exp_sfr[16]);
    acc_en = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule